// File: doc/BRIEF.md
# Paged Host Window Bridge

This block sits behind a host link and turns single-word host requests, each aimed at one of three fixed-size windows, into cycles on a wide internal bus. The host selects a window with a two-bit code and supplies a byte offset inside it. A small control window holds two page registers, an error flag and a communication-reset trigger. A 1 MiB data window is placed inside a 2 GiB memory space by the data page register. A 512 KiB register window reaches a 16 MiB register space. On that window every internal 32-bit word is spread over 32 host bytes, so the host offset is scaled down by eight, and the register page supplies the high address bits.

Each request completes through a valid/ready handshake. Only one internal cycle is ever open, and the host waits until the internal bus acknowledges it. Any access that is not a whole, aligned 32-bit word is turned back without touching the bus. Such an access returns all ones and sets a sticky error flag.

Top module: `page_window_bridge`

## Requirements
- R1: Window code 1 (data window): the internal cycle carries address {dataPage[10:0], hostAddr[19:0]}, wbRegSel low, wbWe equal to hostWrite, wbDatW equal to hostWdata, and wbSel 4'hF.
- R2: Window code 2 (register window): the internal address is {regPage[7:0], hostAddr[18:3]} zero-extended to 31 bits, and wbRegSel is high. With the register page at zero, host offset 0x0800 gives 0x0100 and host offset 0x0820 gives 0x0104.
- R3: Window code 0 (control window) never starts an internal cycle. Offset 0x00 holds the data page (low 11 bits, read/write). Offset 0x04 holds the register page (low 8 bits, read/write). Offset 0x08 reads as 0. Offset 0x0C reads the error flag in bit 0. Every other offset reads 0 and ignores writes.
- R4: Any write to control offset 0x08 drives commRst high for exactly one cycle, in the same cycle as hostReady. Both page registers read 0 afterwards.
- R5: A request is rejected when any of the following holds: hostBe is not 4'hF, hostAddr[1:0] is not zero, the window code is 3, or a register-window offset has nonzero bits [2:0] or bit 19 set. A rejected request starts no internal cycle, returns 32'hFFFFFFFF and sets errFlag.
- R6: errFlag stays set until a control write to offset 0x0C with data bit 0 equal to 1. A write there with bit 0 equal to 0 leaves the flag unchanged. The flag is 0 after reset.
- R7: At most one internal cycle is open. While it waits for wbAck, wbCyc and wbStb stay high and the address, data and write enable stay stable.
- R8: hostReady stays low while an internal cycle is open. It is high for exactly one cycle, the cycle after wbAck is sampled, with hostRdata equal to the wbDatR captured at the acknowledge. Control and rejected requests raise hostReady in the first cycle after the request is accepted.
- R9: After reset, hostReady, wbCyc, commRst and errFlag are low, and both page registers are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| hostValid | input | 1 | Host request valid, held until hostReady |
| hostReady | output | 1 | One-cycle completion of the host request |
| hostWin | input | 2 | Window code: 0 control, 1 data, 2 register, 3 unmapped |
| hostAddr | input | 20 | Byte offset inside the window |
| hostWrite | input | 1 | Request is a write |
| hostWdata | input | 32 | Write data |
| hostBe | input | 4 | Byte enables; only 4'hF is accepted |
| hostRdata | output | 32 | Read data, valid while hostReady is high |
| errFlag | output | 1 | Sticky rejection flag |
| commRst | output | 1 | One-cycle communication-reset pulse |
| wbCyc | output | 1 | Internal bus cycle |
| wbStb | output | 1 | Internal bus strobe |
| wbWe | output | 1 | Internal bus write enable |
| wbRegSel | output | 1 | High when the cycle targets the register space |
| wbAdr | output | 31 | Internal byte address |
| wbDatW | output | 32 | Internal write data |
| wbSel | output | 4 | Internal byte selects |
| wbDatR | input | 32 | Internal read data |
| wbAck | input | 1 | Internal acknowledge |

## Verification
A request presented before a rising edge is accepted at that edge when the bridge is idle. Control and rejected requests have hostReady high, together with commRst where it applies, in the cycle right after that edge. Bus requests have wbCyc high from the cycle after acceptance until the edge that samples wbAck, and hostReady high in the next cycle. The bench samples every output 1 ns after each rising edge and counts those samples from the edge of acceptance. It requires hostReady on exactly the first sample for control and rejected requests, and on exactly the sample that still shows the acknowledge for bus requests. It checks commRst low again on the sample that follows.

// File: rtl/pwb_pkg.sv
package pwb_pkg;

  typedef enum logic [1:0] {
    WIN_CTL  = 2'd0,
    WIN_MEM  = 2'd1,
    WIN_REG  = 2'd2,
    WIN_NONE = 2'd3
  } winSel_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_BUS  = 2'd1,
    ST_RESP = 2'd2
  } bridgeState_e;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic launch;     // latch a composed bus request
    logic capture;    // latch bus read data
    logic respErr;    // answer a rejected request
    logic ctlAccess;  // perform a control-window access
  } ctlStrobe_t;

  // request classification from the datapath to the sequencer
  typedef struct packed {
    logic isBad;
    logic isCtl;
  } reqClass_t;

endpackage

// File: rtl/pwb_ctrl.sv
module pwb_ctrl
  import pwb_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       hostValid,
  input  reqClass_t  cls,
  input  logic       wbAck,
  output logic       hostReady,
  output logic       wbCyc,
  output logic       wbStb,
  output ctlStrobe_t strobe
);

  bridgeState_e state;
  bridgeState_e nextState;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    strobe    = '0;
    nextState = state;
    hostReady = 1'b0;
    wbCyc     = 1'b0;
    wbStb     = 1'b0;
    case (state)
      ST_IDLE: begin
        if (hostValid) begin
          if (cls.isBad) begin
            strobe.respErr = 1'b1;
            nextState      = ST_RESP;
          end else if (cls.isCtl) begin
            strobe.ctlAccess = 1'b1;
            nextState        = ST_RESP;
          end else begin
            strobe.launch = 1'b1;
            nextState     = ST_BUS;
          end
        end
      end
      ST_BUS: begin
        wbCyc = 1'b1;
        wbStb = 1'b1;
        if (wbAck) begin
          strobe.capture = 1'b1;
          nextState      = ST_RESP;
        end
      end
      ST_RESP: begin
        hostReady = 1'b1;
        nextState = ST_IDLE;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  // R8: completion follows the acknowledge by one cycle
  a_r8_ready_after_ack: assert property (@(posedge clk) disable iff (!rstN)
    (wbCyc && wbAck) |=> hostReady);

  // R8: completion lasts a single cycle
  a_r8_ready_single: assert property (@(posedge clk) disable iff (!rstN)
    hostReady |=> !hostReady);

  // R7: an open cycle stays open until acknowledged
  a_r7_cyc_until_ack: assert property (@(posedge clk) disable iff (!rstN)
    (wbCyc && !wbAck) |=> wbCyc);

endmodule

// File: rtl/pwb_datapath.sv
module pwb_datapath
  import pwb_pkg::*;
#(
  parameter int HOST_AW    = 20,
  parameter int MEM_PAGE_W = 11,
  parameter int REG_AW     = 24,
  parameter int REG_WIN_AW = 19,
  parameter int REG_SHIFT  = 3,
  parameter int BUS_AW     = 31
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [1:0]         hostWin,
  input  logic [HOST_AW-1:0] hostAddr,
  input  logic               hostWrite,
  input  logic [31:0]        hostWdata,
  input  logic [3:0]         hostBe,
  input  logic [31:0]        wbDatR,
  input  ctlStrobe_t         strobe,
  output reqClass_t          cls,
  output logic [BUS_AW-1:0]  wbAdr,
  output logic               wbRegSel,
  output logic               wbWe,
  output logic [31:0]        wbDatW,
  output logic [3:0]         wbSel,
  output logic [31:0]        hostRdata,
  output logic               errFlag,
  output logic               commRst
);

  localparam int REG_OFF_W  = REG_WIN_AW - REG_SHIFT;
  localparam int REG_PAGE_W = REG_AW - REG_OFF_W;
  localparam int MEM_AW     = MEM_PAGE_W + HOST_AW;

  winSel_e               win;
  logic [MEM_PAGE_W-1:0] memPageQ;
  logic [REG_PAGE_W-1:0] regPageQ;
  logic [BUS_AW-1:0]     adrQ;
  logic                  regSelQ;
  logic                  weQ;
  logic [31:0]           datQ;
  logic [3:0]            selQ;
  logic [31:0]           rdataQ;
  logic                  errQ;
  logic                  commRstQ;

  logic                  wordAligned;
  logic                  fullWord;
  logic                  regOffsetOk;
  logic                  ctlInMap;
  logic [1:0]            ctlIdx;
  logic [31:0]           ctlRead;
  logic [MEM_AW-1:0]     memTarget;
  logic [REG_AW-1:0]     regTarget;
  logic [BUS_AW-1:0]     busTarget;

  assign win = winSel_e'(hostWin);

  // request classification
  always_comb begin
    wordAligned = (hostAddr[1:0] == 2'b00);
    fullWord    = (hostBe == 4'hF);
    regOffsetOk = (hostAddr[REG_SHIFT-1:0] == '0) &&
                  ((hostAddr >> REG_WIN_AW) == '0);
    cls.isBad   = !fullWord || !wordAligned || (win == WIN_NONE) ||
                  ((win == WIN_REG) && !regOffsetOk);
    cls.isCtl   = (win == WIN_CTL);
  end

  // control window decode: four words at the bottom of the window
  always_comb begin
    ctlInMap = ((hostAddr >> 4) == '0);
    ctlIdx   = hostAddr[3:2];
    ctlRead  = '0;
    if (ctlInMap) begin
      case (ctlIdx)
        2'd0:    ctlRead = 32'(memPageQ);
        2'd1:    ctlRead = 32'(regPageQ);
        2'd3:    ctlRead = {31'd0, errQ};
        default: ctlRead = '0;
      endcase
    end
  end

  // address composition for the two bus windows
  always_comb begin
    memTarget = {memPageQ, hostAddr};
    regTarget = {regPageQ, hostAddr[REG_WIN_AW-1:REG_SHIFT]};
    if (win == WIN_REG) busTarget = BUS_AW'(regTarget);
    else                busTarget = BUS_AW'(memTarget);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      memPageQ <= '0;
      regPageQ <= '0;
      adrQ     <= '0;
      regSelQ  <= 1'b0;
      weQ      <= 1'b0;
      datQ     <= '0;
      selQ     <= '0;
      rdataQ   <= '0;
      errQ     <= 1'b0;
      commRstQ <= 1'b0;
    end else begin
      commRstQ <= 1'b0;
      if (strobe.launch) begin
        adrQ    <= busTarget;
        regSelQ <= (win == WIN_REG);
        weQ     <= hostWrite;
        datQ    <= hostWdata;
        selQ    <= hostBe;
      end
      if (strobe.capture) rdataQ <= wbDatR;
      if (strobe.respErr) begin
        rdataQ <= '1;
        errQ   <= 1'b1;
      end
      if (strobe.ctlAccess) begin
        rdataQ <= ctlRead;
        if (hostWrite && ctlInMap) begin
          case (ctlIdx)
            2'd0: memPageQ <= hostWdata[MEM_PAGE_W-1:0];
            2'd1: regPageQ <= hostWdata[REG_PAGE_W-1:0];
            2'd2: begin
              memPageQ <= '0;
              regPageQ <= '0;
              commRstQ <= 1'b1;
            end
            default: if (hostWdata[0]) errQ <= 1'b0;
          endcase
        end
      end
    end
  end

  assign wbAdr     = adrQ;
  assign wbRegSel  = regSelQ;
  assign wbWe      = weQ;
  assign wbDatW    = datQ;
  assign wbSel     = selQ;
  assign hostRdata = rdataQ;
  assign errFlag   = errQ;
  assign commRst   = commRstQ;

  // R6: the flag only falls through a control access
  a_r6_err_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (errFlag && !strobe.ctlAccess) |=> errFlag);

  // R5: a rejected request answers all ones and flags it
  a_r5_reject_answer: assert property (@(posedge clk) disable iff (!rstN)
    strobe.respErr |=> (errFlag && (hostRdata == 32'hFFFF_FFFF)));

  // R4: the reset pulse is one cycle wide
  a_r4_pulse_single: assert property (@(posedge clk) disable iff (!rstN)
    commRst |=> !commRst);

  // R4: pages are clear while the pulse is out
  a_r4_pages_zero: assert property (@(posedge clk) disable iff (!rstN)
    commRst |-> ((memPageQ == '0) && (regPageQ == '0)));

endmodule

// File: rtl/page_window_bridge.sv
module page_window_bridge
  import pwb_pkg::*;
#(
  parameter int HOST_AW    = 20,
  parameter int MEM_PAGE_W = 11,
  parameter int REG_AW     = 24,
  parameter int REG_WIN_AW = 19,
  parameter int REG_SHIFT  = 3,
  localparam int MEM_AW    = MEM_PAGE_W + HOST_AW,
  localparam int BUS_AW    = (MEM_AW > REG_AW) ? MEM_AW : REG_AW
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               hostValid,
  output logic               hostReady,
  input  logic [1:0]         hostWin,
  input  logic [HOST_AW-1:0] hostAddr,
  input  logic               hostWrite,
  input  logic [31:0]        hostWdata,
  input  logic [3:0]         hostBe,
  output logic [31:0]        hostRdata,
  output logic               errFlag,
  output logic               commRst,
  output logic               wbCyc,
  output logic               wbStb,
  output logic               wbWe,
  output logic               wbRegSel,
  output logic [BUS_AW-1:0]  wbAdr,
  output logic [31:0]        wbDatW,
  output logic [3:0]         wbSel,
  input  logic [31:0]        wbDatR,
  input  logic               wbAck
);

  ctlStrobe_t strobeW;
  reqClass_t  clsW;

  pwb_ctrl ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .hostValid (hostValid),
    .cls       (clsW),
    .wbAck     (wbAck),
    .hostReady (hostReady),
    .wbCyc     (wbCyc),
    .wbStb     (wbStb),
    .strobe    (strobeW)
  );

  pwb_datapath #(
    .HOST_AW    (HOST_AW),
    .MEM_PAGE_W (MEM_PAGE_W),
    .REG_AW     (REG_AW),
    .REG_WIN_AW (REG_WIN_AW),
    .REG_SHIFT  (REG_SHIFT),
    .BUS_AW     (BUS_AW)
  ) datapath_i (
    .clk       (clk),
    .rstN      (rstN),
    .hostWin   (hostWin),
    .hostAddr  (hostAddr),
    .hostWrite (hostWrite),
    .hostWdata (hostWdata),
    .hostBe    (hostBe),
    .wbDatR    (wbDatR),
    .strobe    (strobeW),
    .cls       (clsW),
    .wbAdr     (wbAdr),
    .wbRegSel  (wbRegSel),
    .wbWe      (wbWe),
    .wbDatW    (wbDatW),
    .wbSel     (wbSel),
    .hostRdata (hostRdata),
    .errFlag   (errFlag),
    .commRst   (commRst)
  );

  // R7: request fields hold while the cycle waits
  a_r7_hold_request: assert property (@(posedge clk) disable iff (!rstN)
    (wbCyc && !wbAck) |=> ($stable(wbAdr) && $stable(wbWe) && $stable(wbDatW)
                           && $stable(wbRegSel)));

  // R5: a bus cycle only opens for an accepted, well-formed request
  a_r5_no_bus_on_bad: assert property (@(posedge clk) disable iff (!rstN)
    $rose(wbCyc) |-> !$past(clsW.isBad));

  // R8: no completion while a cycle is open
  a_r8_quiet_while_open: assert property (@(posedge clk) disable iff (!rstN)
    (wbCyc && !wbAck) |=> !hostReady);

endmodule

// File: tb/page_window_bridge_tb_top.sv
`timescale 1ns/1ps
module page_window_bridge_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        hostValid = 1'b0;
  logic        hostReady;
  logic [1:0]  hostWin = '0;
  logic [19:0] hostAddr = '0;
  logic        hostWrite = 1'b0;
  logic [31:0] hostWdata = '0;
  logic [3:0]  hostBe = 4'hF;
  logic [31:0] hostRdata;
  logic        errFlag;
  logic        commRst;
  logic        wbCyc;
  logic        wbStb;
  logic        wbWe;
  logic        wbRegSel;
  logic [30:0] wbAdr;
  logic [31:0] wbDatW;
  logic [3:0]  wbSel;
  logic [31:0] wbDatR = '0;
  logic        wbAck = 1'b0;

  int checks = 0;
  int errors = 0;
  int slaveWait = 0;
  logic [10:0] memPageM = '0;
  logic [7:0]  regPageM = '0;
  logic        errM = 1'b0;
  logic [31:0] lastRead;
  logic        lastCommRst;

  always #2 clk = ~clk;

  page_window_bridge dut_i (
    .clk(clk), .rstN(rstN), .hostValid(hostValid), .hostReady(hostReady),
    .hostWin(hostWin), .hostAddr(hostAddr), .hostWrite(hostWrite),
    .hostWdata(hostWdata), .hostBe(hostBe), .hostRdata(hostRdata),
    .errFlag(errFlag), .commRst(commRst), .wbCyc(wbCyc), .wbStb(wbStb),
    .wbWe(wbWe), .wbRegSel(wbRegSel), .wbAdr(wbAdr), .wbDatW(wbDatW),
    .wbSel(wbSel), .wbDatR(wbDatR), .wbAck(wbAck)
  );

  function automatic logic [31:0] slaveData(input logic [30:0] adr, input logic rs);
    logic [31:0] mix;
    mix = {1'b0, adr} * 32'h9E37_79B1;
    return mix ^ (rs ? 32'h5A5A_0000 : 32'h0000_00C3);
  endfunction

  function automatic logic [30:0] expAdr(input logic [1:0] win, input logic [19:0] a,
                                         input logic [10:0] mp, input logic [7:0] rp);
    if (win == 2'd2) return {7'd0, rp, a[18:3]};
    return {mp, a};
  endfunction

  function automatic bit expBad(input logic [1:0] win, input logic [19:0] a,
                                input logic [3:0] be);
    if (be != 4'hF) return 1'b1;
    if (a[1:0] != 2'b00) return 1'b1;
    if (win == 2'd3) return 1'b1;
    if (win == 2'd2 && (a[2:0] != 3'd0 || a[19])) return 1'b1;
    return 1'b0;
  endfunction

  // slave answering after 0..3 wait cycles
  always @(negedge clk) begin
    if (!wbCyc) begin
      wbAck = 1'b0;
      slaveWait = $urandom % 4;
    end else if (wbAck) begin
      wbAck = 1'b0;
    end else if (slaveWait == 0) begin
      wbAck = 1'b1;
      wbDatR = slaveData(wbAdr, wbRegSel);
    end else begin
      slaveWait = slaveWait - 1;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic access(input logic [1:0] win, input logic [19:0] a, input logic wr,
                        input logic [31:0] wd, input logic [3:0] be);
    bit bad, isCtl, sawCyc, stableOk, readyAtAck, done;
    int cycles;
    logic [30:0] adrSeen, eAdr;
    logic rsSeen, weSeen;
    logic [31:0] datSeen, rd, eRead;
    logic [3:0] selSeen;
    bad = expBad(win, a, be);
    isCtl = (win == 2'd0);
    eAdr = expAdr(win, a, memPageM, regPageM);
    eRead = 32'd0;
    if (isCtl && (a >> 4) == 0) begin
      case (a[3:2])
        2'd0: eRead = {21'd0, memPageM};
        2'd1: eRead = {24'd0, regPageM};
        2'd3: eRead = {31'd0, errM};
        default: eRead = 32'd0;
      endcase
    end
    @(negedge clk);
    hostValid = 1'b1; hostWin = win; hostAddr = a; hostWrite = wr;
    hostWdata = wd; hostBe = be;
    cycles = 0; sawCyc = 0; stableOk = 1; readyAtAck = 0; done = 0;
    adrSeen = '0; rsSeen = 0; weSeen = 0; datSeen = '0; selSeen = '0; rd = '0;
    while (!done) begin
      @(posedge clk); #1;
      cycles++;
      if (wbCyc) begin
        if (!sawCyc) begin
          sawCyc = 1; adrSeen = wbAdr; rsSeen = wbRegSel; weSeen = wbWe;
          datSeen = wbDatW; selSeen = wbSel;
        end else if (wbAdr != adrSeen || wbWe != weSeen || wbDatW != datSeen) begin
          stableOk = 0;
        end
      end
      if (hostReady) begin
        done = 1; rd = hostRdata; readyAtAck = wbAck; lastCommRst = commRst;
      end else if (cycles > 40) begin
        done = 1;
        check(0, "R8", "no completion", 32'(cycles), 32'd0);
      end
    end
    lastRead = rd;
    if (bad) begin
      errM = 1'b1;
      check(!sawCyc, "R5", "rejected request opened a cycle", 32'(sawCyc), 32'd0);
      check(rd == 32'hFFFF_FFFF, "R5", "rejected read data", rd, 32'hFFFF_FFFF);
      check(cycles == 1, "R8", "rejected completion latency", 32'(cycles), 32'd1);
    end else if (isCtl) begin
      check(!sawCyc, "R3", "control access opened a cycle", 32'(sawCyc), 32'd0);
      check(cycles == 1, "R8", "control completion latency", 32'(cycles), 32'd1);
      if (!wr) check(rd == eRead, "R3", "control read", rd, eRead);
      if (wr && (a >> 4) == 0) begin
        case (a[3:2])
          2'd0: memPageM = wd[10:0];
          2'd1: regPageM = wd[7:0];
          2'd2: begin memPageM = '0; regPageM = '0; end
          default: if (wd[0]) errM = 1'b0;
        endcase
      end
      check(lastCommRst == (wr && (a >> 4) == 0 && a[3:2] == 2'd2), "R4",
            "commRst at completion", 32'(lastCommRst), 32'(wr && a[3:2] == 2'd2));
    end else begin
      check(sawCyc, "R1", "bus cycle missing", 32'(sawCyc), 32'd1);
      check(adrSeen == eAdr, (win == 2'd2) ? "R2" : "R1", "bus address",
            32'(adrSeen), 32'(eAdr));
      check(rsSeen == (win == 2'd2), "R2", "register select", 32'(rsSeen),
            32'(win == 2'd2));
      check(weSeen == wr && selSeen == 4'hF, "R1", "write enable and selects",
            {27'd0, selSeen, weSeen}, {27'd0, 4'hF, wr});
      if (wr) check(datSeen == wd, "R1", "write data", datSeen, wd);
      check(stableOk, "R7", "request changed while waiting", 32'(stableOk), 32'd1);
      check(readyAtAck, "R8", "ready not in cycle after ack", 32'(readyAtAck), 32'd1);
      if (!wr) check(rd == slaveData(eAdr, win == 2'd2), "R8", "bus read data", rd,
                     slaveData(eAdr, win == 2'd2));
    end
    check(errFlag == errM, "R6", "error flag", 32'(errFlag), 32'(errM));
    @(negedge clk);
    hostValid = 1'b0;
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=0", 1);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    @(posedge clk); #1;
    // R9: reset state
    check(!hostReady && !wbCyc && !commRst && !errFlag, "R9", "reset outputs",
          {28'd0, hostReady, wbCyc, commRst, errFlag}, 32'd0);
    access(2'd0, 20'h0, 1'b0, 32'd0, 4'hF);
    check(lastRead == 32'd0, "R9", "data page after reset", lastRead, 32'd0);

    // R2: register-window scaling
    access(2'd2, 20'h00800, 1'b0, 32'd0, 4'hF);
    access(2'd2, 20'h00820, 1'b1, 32'hCAFE_0001, 4'hF);
    // R1: data window at the highest page and offset
    access(2'd0, 20'h00000, 1'b1, 32'h0000_07FF, 4'hF);
    access(2'd1, 20'hFFFFC, 1'b0, 32'd0, 4'hF);
    access(2'd0, 20'h00004, 1'b1, 32'h0000_00A5, 4'hF);
    access(2'd2, 20'h7FFF8, 1'b1, 32'h1234_5678, 4'hF);
    // R3: unmapped control offset ignores writes
    access(2'd0, 20'h00010, 1'b1, 32'hFFFF_FFFF, 4'hF);
    access(2'd0, 20'h00000, 1'b0, 32'd0, 4'hF);
    check(lastRead == 32'h7FF, "R3", "page after ignored write", lastRead, 32'h7FF);
    // R5: rejections
    access(2'd2, 20'h00804, 1'b0, 32'd0, 4'hF);
    access(2'd1, 20'h00100, 1'b1, 32'd5, 4'h3);
    access(2'd3, 20'h00000, 1'b0, 32'd0, 4'hF);
    access(2'd2, 20'h80000, 1'b0, 32'd0, 4'hF);
    access(2'd1, 20'h00102, 1'b0, 32'd0, 4'hF);
    // R6: bit 0 clear leaves the flag, bit 0 set clears it
    access(2'd0, 20'h0000C, 1'b1, 32'h0000_0002, 4'hF);
    access(2'd0, 20'h0000C, 1'b1, 32'h0000_0001, 4'hF);
    // R4: communication reset clears both pages
    access(2'd0, 20'h00008, 1'b1, 32'd0, 4'hF);
    @(posedge clk); #1;
    check(!commRst, "R4", "pulse longer than one cycle", 32'(commRst), 32'd0);
    access(2'd0, 20'h00004, 1'b0, 32'd0, 4'hF);
    check(lastRead == 32'd0, "R4", "register page after reset", lastRead, 32'd0);

    for (int n = 0; n < 500; n++) begin
      int r;
      logic [1:0] w;
      logic [19:0] a;
      logic [3:0] be;
      r = $urandom % 100;
      w = (r < 12) ? 2'd0 : (r < 52) ? 2'd1 : (r < 92) ? 2'd2 : 2'd3;
      a = 20'($urandom);
      if (w == 2'd0) begin
        int k;
        k = $urandom % 20;
        a = (k < 7) ? 20'h0 : (k < 13) ? 20'h4 : (k == 13) ? 20'h8 :
            (k < 17) ? 20'hC : 20'(16 + ($urandom % 8) * 4);
      end else if (w == 2'd1) begin
        if ($urandom % 20 != 0) a[1:0] = 2'b00;
      end else if (w == 2'd2) begin
        if ($urandom % 10 != 0) a[2:0] = 3'd0;
        if ($urandom % 20 != 0) a[19] = 1'b0;
      end
      be = ($urandom % 12 == 0) ? 4'($urandom % 15) : 4'hF;
      access(w, a, 1'($urandom), $urandom, be);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule